// File: doc/BRIEF.md
# Display Register-Write Command Sequencer

This block executes a prepared list of commands that reprogram display-pipeline registers. Software fills a command memory with 8-byte command slots, sets a head pointer and then writes the tail pointer while the block is enabled. The sequencer reads the slots from head to tail and turns each one into register writes on a write master port. It can also stall until vertical blanking begins, so that register updates land outside the active picture.

Four commands are decoded. A single write sends one 32-bit word to one register offset. An indexed write streams a counted run of data words to the same offset, which makes bulk tables such as lookup tables compact. A no-operation only advances the pointer, and a vblank wait holds execution until the next start of vertical blanking. Writes are masked only through per-byte enables. In the optional non-posted mode every write waits for an acknowledge from the register bus before the sequencer does anything else.

The command-memory request and the register write each use a valid/ready handshake. Once valid is raised, the address or the write payload stays stable until ready is seen. The sequencer never has more than one memory read in flight, so the read response has no ready: it is taken in the cycle it arrives. Control inputs and status outputs are plain levels or strobes.

Top module: `cmdseq_top`

## Requirements
- R1: After reset, busy, error, mem_req_valid and wr_valid are all low.
- R2: A slot with opcode 0x01 in bits [63:56] makes exactly one write: offset from bits [51:32], byte enables from bits [55:52], data from bits [31:0].
- R3: A slot with opcode 0x09 holds the offset and byte enables in the same fields and a word count N in bits [31:0]. It makes N writes to that offset with those enables. Data word i comes from the (i/2)-th following slot: bits [31:0] when i is even, bits [63:32] when i is odd. Execution resumes at the slot after the last data slot. N = 0 makes no write.
- R4: Opcode 0x00, and any opcode other than 0x01, 0x09 and 0x0A, makes no write. The next slot is then fetched.
- R5: Opcode 0x0A makes no write and holds execution until a rising edge of vblank is seen while waiting.
- R6: A cfg_tail_wr strobe starts execution at cfg_head only when cfg_enable is high and the block is idle. Otherwise it is ignored and changes neither busy nor error.
- R7: At a start, if head or tail is not a multiple of LINE_BYTES, or head is greater than tail, error goes high and nothing is fetched. A later valid start clears error. If head equals tail, nothing is fetched and busy stays low.
- R8: If cfg_vbl_start is high at the start, no slot is fetched until a rising edge of vblank.
- R9: If cfg_nonposted is high at the start, each accepted write is followed by wr_ack before any further memory request or write is issued.
- R10: busy stays high from the start until the fetch pointer reaches tail and the last write has completed (accepted when posted, acknowledged when non-posted). Then it falls and no request or write is pending.
- R11: mem_req_valid and wr_valid each keep their address or payload stable until ready is seen.
- R12: Slots are fetched in sequence at addresses head, head+8, and so on up to tail-8. Each slot is fetched exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Allows a tail write to start execution |
| cfg_head | input | ADDR_W | Byte address of the first slot |
| cfg_tail | input | ADDR_W | Byte address one past the last slot |
| cfg_tail_wr | input | 1 | Tail write strobe; starts a run |
| cfg_vbl_start | input | 1 | Hold the first fetch until vblank begins |
| cfg_nonposted | input | 1 | Wait for wr_ack after each write |
| busy | output | 1 | A run is in progress |
| error | output | 1 | The last start had bad pointers |
| mem_req_valid | output | 1 | Command memory read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | ADDR_W | Byte address of the requested slot |
| mem_rsp_valid | input | 1 | Read data is valid |
| mem_rsp_data | input | 64 | One command slot |
| wr_valid | output | 1 | Register write is valid |
| wr_ready | input | 1 | Register bus accepts the write |
| wr_offset | output | 20 | Register offset |
| wr_be | output | 4 | Byte enables |
| wr_data | output | 32 | Write data |
| wr_ack | input | 1 | Write completion pulse (non-posted mode) |
| vblank | input | 1 | Vertical blanking level |

## Verification
The assertions assume that cfg_nonposted does not change while busy is high, and that wr_ack arrives only as a single pulse after an accepted write. They also assume the memory returns exactly one response for each accepted request. The bench meets these assumptions by construction. The mode inputs change only between runs, and the acknowledge model fires one pulse a fixed delay after each accepted write, and only in non-posted runs. The memory model answers one cycle after every accepted request, so ready stalls on both ports are the only irregular timing the design sees.

// File: rtl/cmdseq_pkg.sv
package cmdseq_pkg;
  localparam int SLOT_BYTES = 8;
  localparam int OFF_W      = 20;
  localparam int BE_W       = 4;
  localparam int DATA_W     = 32;

  localparam logic [7:0] OP_NOP     = 8'h00;
  localparam logic [7:0] OP_WRITE   = 8'h01;
  localparam logic [7:0] OP_INDEXED = 8'h09;
  localparam logic [7:0] OP_VBLANK  = 8'h0A;

  // One 64-bit command slot, most significant field first.
  typedef struct packed {
    logic [7:0]        op;
    logic [BE_W-1:0]   be;
    logic [OFF_W-1:0]  off;
    logic [DATA_W-1:0] lo;
  } slot_t;

  typedef struct packed {
    logic [OFF_W-1:0]  off;
    logic [BE_W-1:0]   be;
    logic [DATA_W-1:0] data;
  } wreq_t;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_HOLD,
    ST_CFETCH,
    ST_CRSP,
    ST_DFETCH,
    ST_DRSP,
    ST_WRITE,
    ST_VWAIT,
    ST_NEXT
  } seq_state_t;

  typedef enum logic [1:0] {
    WM_IDLE,
    WM_PEND,
    WM_ACK
  } wm_state_t;
endpackage

// File: rtl/cmdseq_ptrchk.sv
module cmdseq_ptrchk #(
  parameter int ADDR_W     = 16,
  parameter int LINE_BYTES = 64
) (
  input  logic [ADDR_W-1:0] head,
  input  logic [ADDR_W-1:0] tail,
  output logic              ok,
  output logic              empty
);
  localparam int LINE_LSB = $clog2(LINE_BYTES);

  logic aligned;

  generate
    if (LINE_LSB == 0) begin : g_no_align
      assign aligned = 1'b1;
    end else begin : g_align
      assign aligned = (head[LINE_LSB-1:0] == '0) && (tail[LINE_LSB-1:0] == '0);
    end
  endgenerate

  assign ok    = aligned && (head <= tail);
  assign empty = (head == tail);
endmodule

// File: rtl/cmdseq_decode.sv
module cmdseq_decode
  import cmdseq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  slot_t             slot,
  output logic              is_write,
  output logic              is_indexed,
  output logic              is_vwait,
  output wreq_t             req,
  output logic [CNT_W-1:0]  count
);
  assign is_write   = (slot.op == OP_WRITE);
  assign is_indexed = (slot.op == OP_INDEXED);
  assign is_vwait   = (slot.op == OP_VBLANK);

  always_comb begin
    req.off  = slot.off;
    req.be   = slot.be;
    req.data = slot.lo;
  end

  assign count = CNT_W'(slot.lo);
endmodule

// File: rtl/cmdseq_edge.sv
module cmdseq_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic rise
);
  logic level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= 1'b0;
    else        level_q <= level;
  end

  assign rise = level & ~level_q;
endmodule

// File: rtl/cmdseq_wrmaster.sv
module cmdseq_wrmaster
  import cmdseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  wreq_t             req_in,
  input  logic              nonposted,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [OFF_W-1:0]  wr_offset,
  output logic [BE_W-1:0]   wr_be,
  output logic [DATA_W-1:0] wr_data,
  input  logic              wr_ack,
  output logic              done
);
  wm_state_t st_q;
  wreq_t     hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= WM_IDLE;
      hold_q <= '0;
    end else if (load) begin
      st_q   <= WM_PEND;
      hold_q <= req_in;
    end else begin
      case (st_q)
        WM_PEND: if (wr_ready) st_q <= nonposted ? WM_ACK : WM_IDLE;
        WM_ACK:  if (wr_ack)   st_q <= WM_IDLE;
        default: st_q <= WM_IDLE;
      endcase
    end
  end

  assign wr_valid  = (st_q == WM_PEND);
  assign wr_offset = hold_q.off;
  assign wr_be     = hold_q.be;
  assign wr_data   = hold_q.data;
  assign done      = ((st_q == WM_PEND) && wr_ready && !nonposted) ||
                     ((st_q == WM_ACK) && wr_ack);
endmodule

// File: rtl/cmdseq_top.sv
module cmdseq_top
  import cmdseq_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int LINE_BYTES = 64,
  parameter int CNT_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_enable,
  input  logic [ADDR_W-1:0] cfg_head,
  input  logic [ADDR_W-1:0] cfg_tail,
  input  logic              cfg_tail_wr,
  input  logic              cfg_vbl_start,
  input  logic              cfg_nonposted,
  output logic              busy,
  output logic              error,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [63:0]       mem_rsp_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [19:0]       wr_offset,
  output logic [3:0]        wr_be,
  output logic [31:0]       wr_data,
  input  logic              wr_ack,
  input  logic              vblank
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(SLOT_BYTES);
  localparam logic [CNT_W-1:0]  ONE  = CNT_W'(1);

  seq_state_t        st_q;
  logic [ADDR_W-1:0] ptr_q, tail_q;
  logic [CNT_W-1:0]  rem_q;
  logic              burst_q, sel_q, np_q, err_q;
  logic [31:0]       hi_q;
  logic [19:0]       boff_q;
  logic [3:0]        bbe_q;

  logic              chk_ok, chk_empty, vbl_rise, start, at_tail;
  logic              dec_write, dec_indexed, dec_vwait;
  wreq_t             dec_req, wm_req;
  logic [CNT_W-1:0]  dec_count;
  logic              wm_load, wm_done;
  slot_t             rsp_slot;

  assign rsp_slot = slot_t'(mem_rsp_data);

  cmdseq_ptrchk #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_chk (
    .head (cfg_head),
    .tail (cfg_tail),
    .ok   (chk_ok),
    .empty(chk_empty)
  );

  cmdseq_decode #(.CNT_W(CNT_W)) u_dec (
    .slot      (rsp_slot),
    .is_write  (dec_write),
    .is_indexed(dec_indexed),
    .is_vwait  (dec_vwait),
    .req       (dec_req),
    .count     (dec_count)
  );

  cmdseq_edge u_vbl (
    .clk  (clk),
    .rst_n(rst_n),
    .level(vblank),
    .rise (vbl_rise)
  );

  cmdseq_wrmaster u_wm (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (wm_load),
    .req_in   (wm_req),
    .nonposted(np_q),
    .wr_valid (wr_valid),
    .wr_ready (wr_ready),
    .wr_offset(wr_offset),
    .wr_be    (wr_be),
    .wr_data  (wr_data),
    .wr_ack   (wr_ack),
    .done     (wm_done)
  );

  assign start   = cfg_tail_wr && cfg_enable && (st_q == ST_IDLE);
  assign at_tail = (ptr_q == tail_q);

  // Selects the write handed to the write master and when it is loaded.
  always_comb begin
    wm_load = 1'b0;
    wm_req  = dec_req;
    case (st_q)
      ST_CRSP: begin
        if (mem_rsp_valid && dec_write) wm_load = 1'b1;
      end
      ST_DRSP: begin
        if (mem_rsp_valid) begin
          wm_load      = 1'b1;
          wm_req.off   = boff_q;
          wm_req.be    = bbe_q;
          wm_req.data  = rsp_slot.lo;
        end
      end
      ST_WRITE: begin
        if (wm_done && burst_q && (rem_q != ONE) && !sel_q) begin
          wm_load      = 1'b1;
          wm_req.off   = boff_q;
          wm_req.be    = bbe_q;
          wm_req.data  = hi_q;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      ptr_q   <= '0;
      tail_q  <= '0;
      rem_q   <= '0;
      burst_q <= 1'b0;
      sel_q   <= 1'b0;
      np_q    <= 1'b0;
      err_q   <= 1'b0;
      hi_q    <= '0;
      boff_q  <= '0;
      bbe_q   <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (start) begin
            if (!chk_ok) begin
              err_q <= 1'b1;
            end else begin
              err_q <= 1'b0;
              if (!chk_empty) begin
                ptr_q  <= cfg_head;
                tail_q <= cfg_tail;
                np_q   <= cfg_nonposted;
                st_q   <= cfg_vbl_start ? ST_HOLD : ST_CFETCH;
              end
            end
          end
        end
        ST_HOLD: begin
          if (vbl_rise) st_q <= ST_CFETCH;
        end
        ST_CFETCH: begin
          if (mem_req_ready) st_q <= ST_CRSP;
        end
        ST_CRSP: begin
          if (mem_rsp_valid) begin
            ptr_q   <= ptr_q + STEP;
            burst_q <= 1'b0;
            if (dec_write) begin
              st_q <= ST_WRITE;
            end else if (dec_indexed) begin
              boff_q <= rsp_slot.off;
              bbe_q  <= rsp_slot.be;
              rem_q  <= dec_count;
              if (dec_count == '0) begin
                st_q <= ST_NEXT;
              end else begin
                burst_q <= 1'b1;
                st_q    <= ST_DFETCH;
              end
            end else if (dec_vwait) begin
              st_q <= ST_VWAIT;
            end else begin
              st_q <= ST_NEXT;
            end
          end
        end
        ST_DFETCH: begin
          if (at_tail) begin
            burst_q <= 1'b0;
            st_q    <= ST_IDLE;
          end else if (mem_req_ready) begin
            st_q <= ST_DRSP;
          end
        end
        ST_DRSP: begin
          if (mem_rsp_valid) begin
            ptr_q <= ptr_q + STEP;
            hi_q  <= mem_rsp_data[63:32];
            sel_q <= 1'b0;
            st_q  <= ST_WRITE;
          end
        end
        ST_WRITE: begin
          if (wm_done) begin
            if (!burst_q) begin
              st_q <= ST_NEXT;
            end else if (rem_q == ONE) begin
              burst_q <= 1'b0;
              st_q    <= ST_NEXT;
            end else begin
              rem_q <= rem_q - ONE;
              if (!sel_q) sel_q <= 1'b1;
              else        st_q  <= ST_DFETCH;
            end
          end
        end
        ST_VWAIT: begin
          if (vbl_rise) st_q <= ST_NEXT;
        end
        ST_NEXT: begin
          st_q <= at_tail ? ST_IDLE : ST_CFETCH;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_req_valid = (st_q == ST_CFETCH) || ((st_q == ST_DFETCH) && !at_tail);
  assign mem_req_addr  = ptr_q;
  assign busy          = (st_q != ST_IDLE);
  assign error         = err_q;
endmodule

// File: rtl/cmdseq_checker.sv
module cmdseq_checker #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              error,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [19:0]       wr_offset,
  input logic [3:0]        wr_be,
  input logic [31:0]       wr_data,
  input logic              wr_ack,
  input logic              cfg_nonposted
);
  logic pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                     pend_q <= 1'b0;
    else if (wr_valid && wr_ready && cfg_nonposted) pend_q <= 1'b1;
    else if (wr_ack)                                pend_q <= 1'b0;
  end

  p_wr_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_offset) && $stable(wr_be) && $stable(wr_data));

  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  p_quiet_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !wr_valid && !mem_req_valid);

  p_err_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> !busy);

  p_slot_align_r12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_addr[2:0] == 3'b000));

  p_np_order_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> !wr_valid && !mem_req_valid);
endmodule

bind cmdseq_top cmdseq_checker #(.ADDR_W(ADDR_W)) u_chkr (
  .clk          (clk),
  .rst_n        (rst_n),
  .busy         (busy),
  .error        (error),
  .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready),
  .mem_req_addr (mem_req_addr),
  .wr_valid     (wr_valid),
  .wr_ready     (wr_ready),
  .wr_offset    (wr_offset),
  .wr_be        (wr_be),
  .wr_data      (wr_data),
  .wr_ack       (wr_ack),
  .cfg_nonposted(cfg_nonposted)
);

// File: tb/cmdseq_top_tb.sv
module cmdseq_top_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        cfg_enable = 1'b1, cfg_tail_wr = 1'b0, cfg_vbl_start = 1'b0, cfg_nonposted = 1'b0;
  logic [15:0] cfg_head = '0, cfg_tail = '0;
  logic        busy, error, mem_req_valid, mem_req_ready, mem_rsp_valid = 1'b0;
  logic [15:0] mem_req_addr;
  logic [63:0] mem_rsp_data = '0;
  logic        wr_valid, wr_ready, wr_ack = 1'b0, vblank = 1'b0;
  logic [19:0] wr_offset;
  logic [3:0]  wr_be;
  logic [31:0] wr_data;

  cmdseq_top u_dut (.*);

  // Models
  int   cyc = 0, stall = 0, ng = 0, nreq = 0, npviol = 0, ack_dly = 0;
  logic np_mode = 1'b0, pend = 1'b0;
  logic [63:0] mem [0:63];
  logic [55:0] wlog [0:2047];
  logic [15:0] alog [0:2047];

  assign mem_req_ready = ((cyc % (stall + 1)) == 0);
  assign wr_ready      = (((cyc + 1) % (stall + 1)) == 0);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    mem_rsp_valid <= mem_req_valid && mem_req_ready;
    mem_rsp_data  <= mem[mem_req_addr[8:3]];
    if (mem_req_valid && mem_req_ready) begin
      alog[nreq[10:0]] <= mem_req_addr;
      nreq <= nreq + 1;
      if (pend) npviol <= npviol + 1;
    end
    if (wr_ack) pend <= 1'b0;
    if (wr_valid && wr_ready) begin
      wlog[ng[10:0]] <= {wr_offset, wr_be, wr_data};
      ng <= ng + 1;
      if (pend) npviol <= npviol + 1;
      if (np_mode) begin pend <= 1'b1; ack_dly <= 3; end
    end else if (ack_dly != 0) ack_dly <= ack_dly - 1;
    wr_ack <= (ack_dly == 1);
  end

  // Bookkeeping
  int checks = 0, errors = 0;
  int pi = 0, ne = 0, ng0 = 0, nr0 = 0, npv0 = 0, hd0 = 0, tl0 = 0;
  logic [19:0] e_off [0:127];
  logic [3:0]  e_be  [0:127];
  logic [31:0] e_data[0:127];

  task automatic check(input bit cond, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic expect_wr(input logic [19:0] off, input logic [3:0] be, input logic [31:0] d);
    e_off[ne] = off; e_be[ne] = be; e_data[ne] = d; ne++;
  endtask

  task automatic begin_prog(input int slot);
    pi = slot; ne = 0;
    for (int i = slot; i < slot + 16 && i < 64; i++) mem[i] = '0;
  endtask

  task automatic put_write(input logic [19:0] off, input logic [3:0] be, input logic [31:0] d);
    mem[pi] = {8'h01, be, off, d}; pi++;
    expect_wr(off, be, d);
  endtask

  task automatic put_index(input logic [19:0] off, input logic [3:0] be, input int n, input logic [31:0] base);
    mem[pi] = {8'h09, be, off, 32'(n)}; pi++;
    for (int i = 0; i < n; i++) begin
      if (i % 2 == 0) mem[pi] = {32'hFFFF_FFFF, base + 32'(i)};
      else begin mem[pi][63:32] = base + 32'(i); pi++; end
      expect_wr(off, be, base + 32'(i));
    end
    if (n % 2 == 1) pi++;
  endtask

  task automatic pad_line();
    while (pi % 8 != 0) begin mem[pi] = '0; pi++; end
  endtask

  task automatic launch(input int hb, input int tb, input bit np, input bit vbs);
    @(negedge clk);
    cfg_head = 16'(hb); cfg_tail = 16'(tb);
    cfg_nonposted = np; np_mode = np; cfg_vbl_start = vbs; cfg_tail_wr = 1'b1;
    ng0 = ng; nr0 = nreq; npv0 = npviol; hd0 = hb; tl0 = tb;
    @(negedge clk);
    cfg_tail_wr = 1'b0;
  endtask

  task automatic wait_idle(input string req);
    int n = 0;
    while (busy && n < 3000) begin @(negedge clk); n++; end
    check(!busy, req, "run did not finish", 64'(busy), 64'd0);
  endtask

  task automatic pulse_vblank();
    @(negedge clk); vblank = 1'b1;
    @(negedge clk); vblank = 1'b0;
  endtask

  task automatic verify_run(input string req);
    int bad = 0;
    check(ng - ng0 == ne, req, "write count", 64'(ng - ng0), 64'(ne));
    for (int i = 0; i < ne && i < ng - ng0; i++)
      check(wlog[(ng0 + i) % 2048] == {e_off[i], e_be[i], e_data[i]}, req, "write payload",
            64'(wlog[(ng0 + i) % 2048]), 64'({e_off[i], e_be[i], e_data[i]}));
    check(nreq - nr0 == (tl0 - hd0) / 8, "R12", "slot fetch count",
          64'(nreq - nr0), 64'((tl0 - hd0) / 8));
    for (int k = 0; k < nreq - nr0; k++)
      if (alog[(nr0 + k) % 2048] != 16'(hd0 + 8 * k)) bad++;
    check(bad == 0, "R12", "fetch address order", 64'(bad), 64'd0);
    check(npviol == npv0, "R9", "activity before ack", 64'(npviol - npv0), 64'd0);
    check(!error, "R7", "error after valid run", 64'(error), 64'd0);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!busy && !error && !mem_req_valid && !wr_valid, "R1", "outputs in reset",
          64'({busy, error, mem_req_valid, wr_valid}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !error && !mem_req_valid && !wr_valid, "R1", "outputs after reset",
          64'({busy, error, mem_req_valid, wr_valid}), 64'd0);

    // R2: every byte-enable pattern on single writes
    stall = 1;
    begin_prog(40);
    for (int i = 0; i < 16; i++)
      put_write(20'hF0000 | 20'(i * 4), 4'(i), 32'hA500_0000 ^ (32'(i) * 32'h0101_0101));
    pad_line();
    launch(320, 448, 0, 0);
    wait_idle("R2");
    verify_run("R2");

    // R4: no-op and an undefined opcode make no write
    begin_prog(32);
    mem[pi] = 64'h0000_0000_1234_5678; pi++;
    mem[pi] = 64'h37F0_0ABC_DEAD_BEEF; pi++;
    put_write(20'h00ABC, 4'h5, 32'h1234_5678);
    pad_line();
    launch(256, 320, 0, 0);
    wait_idle("R4");
    verify_run("R4");

    // R3 / R9 / R10: indexed counts 0..7, posted and non-posted, four stall patterns
    for (int np = 0; np < 2; np++)
      for (int st = 0; st < 4; st++)
        for (int n = 0; n < 8; n++) begin
          int base = ((n + st) % 2) * 8;
          stall = st;
          begin_prog(base);
          put_index(20'h00100 + 20'(n), 4'(n) ^ 4'hA, n, 32'h1000_0000 * 32'(np + 1) + 32'(n * 256 + st * 16));
          put_write(20'h00ABC, 4'hF, 32'hC0DE_0000 + 32'(n));
          pad_line();
          launch(base * 8, base * 8 + 64, np[0], 0);
          wait_idle("R10");
          check(pend == 1'b0, "R10", "busy fell before final ack", 64'(pend), 64'd0);
          verify_run("R3");
        end

    // R5 and R6 (busy): vblank-wait command; tail write while busy ignored
    stall = 1;
    begin_prog(16);
    put_write(20'h00010, 4'hF, 32'h0000_0011);
    mem[pi] = {8'h0A, 56'h0}; pi++;
    put_write(20'h00020, 4'h3, 32'h0000_0022);
    pad_line();
    launch(128, 192, 0, 0);
    repeat (20) @(negedge clk);
    cfg_head = 16'd0; cfg_tail = 16'd12; cfg_tail_wr = 1'b1;
    @(negedge clk); cfg_tail_wr = 1'b0;
    repeat (20) @(negedge clk);
    check(ng - ng0 == 1, "R5", "writes before vblank", 64'(ng - ng0), 64'd1);
    check(busy, "R5", "busy while waiting", 64'(busy), 64'd1);
    check(!error, "R6", "tail write while busy ignored", 64'(error), 64'd0);
    pulse_vblank();
    wait_idle("R5");
    verify_run("R5");

    // R8: start held until vblank, non-posted indexed burst
    begin_prog(24);
    put_index(20'h00003, 4'hC, 3, 32'h7700_0000);
    pad_line();
    launch(192, 256, 1, 1);
    repeat (15) @(negedge clk);
    check(nreq == nr0, "R8", "fetches before vblank", 64'(nreq - nr0), 64'd0);
    check(busy, "R8", "busy while held", 64'(busy), 64'd1);
    pulse_vblank();
    wait_idle("R8");
    verify_run("R8");

    // R7: bad pointers
    launch(8, 64, 0, 0);
    check(error && !busy, "R7", "misaligned head", 64'({error, busy}), 64'b10);
    launch(128, 64, 0, 0);
    check(error && !busy, "R7", "head above tail", 64'({error, busy}), 64'b10);
    repeat (5) @(negedge clk);
    check(nreq == nr0, "R7", "no fetch on error", 64'(nreq - nr0), 64'd0);
    launch(64, 64, 0, 0);
    repeat (3) @(negedge clk);
    check(!error && !busy && nreq == nr0, "R7", "empty buffer clears error",
          64'({error, busy}), 64'd0);

    // R6: tail write while disabled
    cfg_enable = 1'b0;
    launch(0, 64, 0, 0);
    repeat (5) @(negedge clk);
    check(!busy && nreq == nr0, "R6", "start while disabled", 64'({busy, 1'b0}), 64'd0);
    cfg_enable = 1'b1;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors + 1);
    $finish;
  end
endmodule